// File: doc/BRIEF.md
# Detector Front-End Packet Framer

This block turns one event's worth of front-end readout into a fixed-length packet of 16-bit words. A start pulse latches the event context: event number, module address, flag word, beam clock count and the analog-memory cell word. It also latches 256 ten-bit channel samples and eight user words. The block then plays out 273 words, one per clock, wrapped in a start marker and an end marker.

Two strobes travel with every word. One marks control words, the other marks payload words. Downstream logic uses them to delimit and qualify the packet. The framer also builds a vertical parity word, which is the running XOR of the payload, and places it just before the end marker.

The output stream has no back-pressure. There is no ready input, and the consumer must take every word on the clock it appears. A packet, once started, is never held or stretched. A start pulse seen while a packet is in flight is dropped. After the end marker the framer spends at least one idle cycle before the next start marker.

Top module: `det_pkt_framer`

## Requirements
- R1: After reset, and whenever no packet is in flight, `busy_o`, `cav_o` and `dav_o` are 0 and `word_o` is 0x0000. A start seen at a clock edge while idle makes the start marker appear in the next cycle.
- R2: The first word of a packet is 0xFFFF, driven with `cav_o`=1 and `dav_o`=0.
- R3: Word 273 is 0x0000, driven with `cav_o`=1 and `dav_o`=0. Words 2 to 272 carry `cav_o`=0 and `dav_o`=1.
- R4: Words 2 to 6 are, in this order: the constant 2, the event number (bits 9..0), the module address (bits 5..0), the flag word (all 16 bits) and the beam clock count (bits 7..0). All bits above the used field are 0.
- R5: Word 7 is the cell word as given. Words 8 to 263 are channels 1 to 256 in ascending order. Channel k is taken from `chan_i` bits [10k-1:10k-10], and bits 15..10 of each channel word are 0.
- R6: Words 264 to 271 are user words 1 to 8. User word j is taken from `user_i` bits [16j-1:16j-16].
- R7: Word 272 is the bitwise XOR of words 2 through 271.
- R8: A start seen while `busy_o` is 1 has no effect. `busy_o` is 1 for exactly the 273 cycles from the start marker through the end marker.
- R9: All inputs are sampled at the edge that accepts the start pulse. Changes to them later in the packet do not alter that packet.
- R10: A start held high, or raised in the first idle cycle after a packet, is accepted at the next edge. Consecutive packets are therefore separated by exactly one idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one packet; ignored while busy |
| evt_num_i | input | 16 | Event number; low 10 bits used |
| mod_addr_i | input | 16 | Module address; low 6 bits used |
| flag_i | input | 16 | Flag word |
| bclk_i | input | 16 | Beam clock count; low 8 bits used |
| amu_i | input | 16 | Cell word: post-sample cell in high byte, pre-sample cell in low byte |
| chan_i | input | 2560 | 256 channel samples of 10 bits, channel 1 in the lowest slice |
| user_i | input | 128 | Eight user words, user word 1 in the lowest slice |
| word_o | output | 16 | Output word |
| cav_o | output | 1 | Control-word strobe (markers) |
| dav_o | output | 1 | Payload-word strobe |
| busy_o | output | 1 | High while a packet is in flight |

## Verification
The assertions take for granted that `start_i` is a known level at every clock edge after reset. They also assume reset is held across the first edge, so their busy-length counter starts from zero. No assumption is needed about the data inputs, because the framer captures them at start. For the same reason, the stimulus deliberately rewrites every data input and pulses start in the middle of a packet. The stimulus drives all inputs only on falling edges, keeps start defined at all times, and asserts reset from time zero.

// File: rtl/fpk_pkg.sv
package fpk_pkg;

  // Which part of the packet the sequencer is emitting this cycle
  typedef enum logic [2:0] {
    SEG_IDLE,
    SEG_SOP,
    SEG_HDR,
    SEG_AMU,
    SEG_CHAN,
    SEG_USER,
    SEG_PAR,
    SEG_EOP
  } fpk_seg_e;

  // Number of header words between the start marker and the cell word
  localparam int FPK_HDR_N = 5;

  localparam logic [15:0] FPK_SOP_WORD = 16'hFFFF;
  localparam logic [15:0] FPK_EOP_WORD = 16'h0000;

endpackage

// File: rtl/fpk_seq.sv
module fpk_seq
  import fpk_pkg::*;
#(
  parameter int NCH   = 256,
  parameter int NUSER = 8,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             active_o,
  output logic             load_o,
  output fpk_seg_e         seg_o,
  output logic [IDX_W-1:0] sub_o
);

  localparam int P_HDR = 1;
  localparam int P_AMU = P_HDR + FPK_HDR_N;
  localparam int P_CH  = P_AMU + 1;
  localparam int P_USR = P_CH + NCH;
  localparam int P_PAR = P_USR + NUSER;
  localparam int P_EOP = P_PAR + 1;

  logic [IDX_W-1:0] idx_q;
  logic             act_q;

  assign load_o   = start_i & ~act_q;
  assign active_o = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (!act_q) begin
      if (start_i) begin
        act_q <= 1'b1;
        idx_q <= '0;
      end
    end else if (idx_q == IDX_W'(P_EOP)) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    seg_o = SEG_IDLE;
    sub_o = '0;
    if (act_q) begin
      if (idx_q == '0) begin
        seg_o = SEG_SOP;
      end else if (idx_q < IDX_W'(P_AMU)) begin
        seg_o = SEG_HDR;
        sub_o = idx_q - IDX_W'(P_HDR);
      end else if (idx_q == IDX_W'(P_AMU)) begin
        seg_o = SEG_AMU;
      end else if (idx_q < IDX_W'(P_USR)) begin
        seg_o = SEG_CHAN;
        sub_o = idx_q - IDX_W'(P_CH);
      end else if (idx_q < IDX_W'(P_PAR)) begin
        seg_o = SEG_USER;
        sub_o = idx_q - IDX_W'(P_USR);
      end else if (idx_q == IDX_W'(P_PAR)) begin
        seg_o = SEG_PAR;
      end else begin
        seg_o = SEG_EOP;
      end
    end
  end

endmodule

// File: rtl/fpk_capture.sv
module fpk_capture
  import fpk_pkg::*;
#(
  parameter int NCH    = 256,
  parameter int SW     = 10,
  parameter int NUSER  = 8,
  parameter int W      = 16,
  parameter int EVT_W  = 10,
  parameter int ADDR_W = 6,
  parameter int BCLK_W = 8,
  parameter int DET_ID = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [W-1:0]           evt_i,
  input  logic [W-1:0]           addr_i,
  input  logic [W-1:0]           flag_i,
  input  logic [W-1:0]           bclk_i,
  input  logic [W-1:0]           amu_i,
  input  logic [NCH*SW-1:0]      chan_i,
  input  logic [NUSER*W-1:0]     user_i,
  output logic [FPK_HDR_N*W-1:0] hdr_o,
  output logic [W-1:0]           amu_o,
  output logic [NCH*SW-1:0]      chan_o,
  output logic [NUSER*W-1:0]     user_o
);

  // Header slots in emission order, upper unused bits forced to zero
  logic [W-1:0] hdr_next [FPK_HDR_N];

  always_comb begin
    hdr_next[0] = W'(DET_ID);
    hdr_next[1] = W'(evt_i[EVT_W-1:0]);
    hdr_next[2] = W'(addr_i[ADDR_W-1:0]);
    hdr_next[3] = flag_i;
    hdr_next[4] = W'(bclk_i[BCLK_W-1:0]);
  end

  for (genvar h = 0; h < FPK_HDR_N; h++) begin : g_hdr
    always_ff @(posedge clk) begin
      if (!rst_n)      hdr_o[h*W +: W] <= '0;
      else if (load_i) hdr_o[h*W +: W] <= hdr_next[h];
    end
  end

  for (genvar u = 0; u < NUSER; u++) begin : g_user
    always_ff @(posedge clk) begin
      if (!rst_n)      user_o[u*W +: W] <= '0;
      else if (load_i) user_o[u*W +: W] <= user_i[u*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amu_o  <= '0;
      chan_o <= '0;
    end else if (load_i) begin
      amu_o  <= amu_i;
      chan_o <= chan_i;
    end
  end

endmodule

// File: rtl/fpk_parity.sv
module fpk_parity #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] par_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)     par_o <= '0;
    else if (clr_i) par_o <= '0;
    else if (en_i)  par_o <= par_o ^ word_i;
  end

endmodule

// File: rtl/fpk_mux.sv
module fpk_mux
  import fpk_pkg::*;
#(
  parameter int NCH   = 256,
  parameter int SW    = 10,
  parameter int NUSER = 8,
  parameter int W     = 16,
  parameter int IDX_W = 9
) (
  input  fpk_seg_e               seg_i,
  input  logic [IDX_W-1:0]       sub_i,
  input  logic [FPK_HDR_N*W-1:0] hdr_i,
  input  logic [W-1:0]           amu_i,
  input  logic [NCH*SW-1:0]      chan_i,
  input  logic [NUSER*W-1:0]     user_i,
  input  logic [W-1:0]           par_i,
  output logic [W-1:0]           word_o,
  output logic                   cav_o,
  output logic                   dav_o
);

  always_comb begin
    word_o = '0;
    cav_o  = 1'b0;
    dav_o  = 1'b0;
    unique case (seg_i)
      SEG_SOP: begin
        word_o = FPK_SOP_WORD;
        cav_o  = 1'b1;
      end
      SEG_HDR: begin
        word_o = hdr_i[int'(sub_i)*W +: W];
        dav_o  = 1'b1;
      end
      SEG_AMU: begin
        word_o = amu_i;
        dav_o  = 1'b1;
      end
      SEG_CHAN: begin
        word_o = W'(chan_i[int'(sub_i)*SW +: SW]);
        dav_o  = 1'b1;
      end
      SEG_USER: begin
        word_o = user_i[int'(sub_i)*W +: W];
        dav_o  = 1'b1;
      end
      SEG_PAR: begin
        word_o = par_i;
        dav_o  = 1'b1;
      end
      SEG_EOP: begin
        word_o = FPK_EOP_WORD;
        cav_o  = 1'b1;
      end
      default: begin
        word_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/det_pkt_framer.sv
module det_pkt_framer
  import fpk_pkg::*;
#(
  parameter int NCH    = 256,
  parameter int SW     = 10,
  parameter int NUSER  = 8,
  parameter int W      = 16,
  parameter int EVT_W  = 10,
  parameter int ADDR_W = 6,
  parameter int BCLK_W = 8,
  parameter int DET_ID = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [W-1:0]         evt_num_i,
  input  logic [W-1:0]         mod_addr_i,
  input  logic [W-1:0]         flag_i,
  input  logic [W-1:0]         bclk_i,
  input  logic [W-1:0]         amu_i,
  input  logic [NCH*SW-1:0]    chan_i,
  input  logic [NUSER*W-1:0]   user_i,
  output logic [W-1:0]         word_o,
  output logic                 cav_o,
  output logic                 dav_o,
  output logic                 busy_o
);

  localparam int TOTAL = 1 + FPK_HDR_N + 1 + NCH + NUSER + 2;
  localparam int IDX_W = $clog2(TOTAL);

  logic                   active;
  logic                   load;
  fpk_seg_e               seg;
  logic [IDX_W-1:0]       sub;
  logic [FPK_HDR_N*W-1:0] hdr_q;
  logic [W-1:0]           amu_q;
  logic [NCH*SW-1:0]      chan_q;
  logic [NUSER*W-1:0]     user_q;
  logic [W-1:0]           par_q;
  logic                   par_en;

  fpk_seq #(
    .NCH   (NCH),
    .NUSER (NUSER),
    .IDX_W (IDX_W)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .active_o (active),
    .load_o   (load),
    .seg_o    (seg),
    .sub_o    (sub)
  );

  fpk_capture #(
    .NCH    (NCH),
    .SW     (SW),
    .NUSER  (NUSER),
    .W      (W),
    .EVT_W  (EVT_W),
    .ADDR_W (ADDR_W),
    .BCLK_W (BCLK_W),
    .DET_ID (DET_ID)
  ) cap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .evt_i  (evt_num_i),
    .addr_i (mod_addr_i),
    .flag_i (flag_i),
    .bclk_i (bclk_i),
    .amu_i  (amu_i),
    .chan_i (chan_i),
    .user_i (user_i),
    .hdr_o  (hdr_q),
    .amu_o  (amu_q),
    .chan_o (chan_q),
    .user_o (user_q)
  );

  fpk_mux #(
    .NCH   (NCH),
    .SW    (SW),
    .NUSER (NUSER),
    .W     (W),
    .IDX_W (IDX_W)
  ) mux_i (
    .seg_i  (seg),
    .sub_i  (sub),
    .hdr_i  (hdr_q),
    .amu_i  (amu_q),
    .chan_i (chan_q),
    .user_i (user_q),
    .par_i  (par_q),
    .word_o (word_o),
    .cav_o  (cav_o),
    .dav_o  (dav_o)
  );

  // Parity covers every payload word from the first header word up to the last user word
  assign par_en = (seg == SEG_HDR) || (seg == SEG_AMU) ||
                  (seg == SEG_CHAN) || (seg == SEG_USER);

  fpk_parity #(
    .W (W)
  ) par_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (load),
    .en_i   (par_en),
    .word_i (word_o),
    .par_o  (par_q)
  );

  assign busy_o = active;

endmodule

// File: rtl/det_pkt_framer_chk.sv
module det_pkt_framer_chk
  import fpk_pkg::*;
#(
  parameter int W     = 16,
  parameter int SW    = 10,
  parameter int TOTAL = 273
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [W-1:0] word_o,
  input logic         cav_o,
  input logic         dav_o,
  input logic         busy_o,
  input fpk_seg_e     seg
);

  logic [15:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!cav_o && !dav_o && word_o == '0));

  // R2
  sop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (cav_o && !dav_o && word_o == W'(16'hFFFF)));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cav_o != dav_o));

  // R3
  eop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && busy_cnt == 16'(TOTAL - 1)) |-> (cav_o && word_o == '0));

  // R5
  chan_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_CHAN) |-> ((word_o >> SW) == '0));

  // R8
  pkt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_cnt == 16'(TOTAL)));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && busy_cnt != 16'(TOTAL - 1)) |=>
      (busy_o && !(cav_o && word_o == W'(16'hFFFF))));

endmodule

bind det_pkt_framer det_pkt_framer_chk #(
  .W     (W),
  .SW    (SW),
  .TOTAL (TOTAL)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .word_o  (word_o),
  .cav_o   (cav_o),
  .dav_o   (dav_o),
  .busy_o  (busy_o),
  .seg     (seg)
);

// File: tb/det_pkt_framer_tb_top.sv
module det_pkt_framer_tb_top;

  localparam int NCH   = 256;
  localparam int SW    = 10;
  localparam int NUSER = 8;
  localparam int TOTAL = 273;
  localparam int WDOG  = 100000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [15:0]        evt, addr, flag, bclk, amu;
  logic [NCH*SW-1:0]  chan;
  logic [NUSER*16-1:0] user;
  logic [15:0]        word_o;
  logic               cav_o, dav_o, busy_o;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  bit    done     = 1'b0;
  string phase    = "base";

  logic [17:0] exp_q[$];

  always #4 clk = ~clk;

  det_pkt_framer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .evt_num_i  (evt),
    .mod_addr_i (addr),
    .flag_i     (flag),
    .bclk_i     (bclk),
    .amu_i      (amu),
    .chan_i     (chan),
    .user_i     (user),
    .word_o     (word_o),
    .cav_o      (cav_o),
    .dav_o      (dav_o),
    .busy_o     (busy_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] cycle %0d actual %h expected %h", req, phase, cyc, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic string tag_of(input int pos);
    if (pos == 0)        return "R2";
    if (pos == TOTAL-1)  return "R3";
    if (pos <= 5)        return "R4";
    if (pos <= 262)      return "R5";
    if (pos <= 270)      return "R6";
    return "R7";
  endfunction

  // Reference packet built from the requirements at the accepting edge
  task automatic build_packet();
    logic [15:0] par;
    logic [15:0] w;
    par = 16'h0;
    exp_q.push_back({2'b10, 16'hFFFF});
    for (int k = 0; k < 5 + 1 + NCH + NUSER; k++) begin
      if (k == 0)      w = 16'd2;
      else if (k == 1) w = {6'b0, evt[9:0]};
      else if (k == 2) w = {10'b0, addr[5:0]};
      else if (k == 3) w = flag;
      else if (k == 4) w = {8'b0, bclk[7:0]};
      else if (k == 5) w = amu;
      else if (k < 6 + NCH) w = {6'b0, chan[(k-6)*SW +: SW]};
      else w = user[(k-6-NCH)*16 +: 16];
      par = par ^ w;
      exp_q.push_back({2'b01, w});
    end
    exp_q.push_back({2'b01, par});
    exp_q.push_back({2'b10, 16'h0000});
  endtask

  // Behavioural model: consumes one word per busy cycle, accepts start only when idle
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) exp_q.delete();
    else if (exp_q.size() > 0) void'(exp_q.pop_front());
    else if (start) build_packet();
    if (cyc >= WDOG && !done) begin
      n_fail++;
      $display("FAIL R8 watchdog actual cycles %0d expected below %0d", cyc, WDOG);
      finish_sim();
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() == 0) begin
        // R1 idle outputs
        check(!busy_o && !cav_o && !dav_o && word_o == 16'h0, "R1",
              {13'b0, busy_o, cav_o, dav_o, word_o}, 32'h0);
      end else begin
        check({cav_o, dav_o, word_o} == exp_q[0], tag_of(TOTAL - exp_q.size()),
              {14'b0, cav_o, dav_o, word_o}, {14'b0, exp_q[0]});
        check(busy_o == 1'b1, "R8", {31'b0, busy_o}, 32'h1);
      end
    end
  end

  task automatic set_inputs(input int seed, input bit ones);
    evt  = ones ? 16'hFFFF : 16'(16'hA000 + seed * 7);
    addr = ones ? 16'hFFFF : 16'(16'h5500 + seed);
    flag = ones ? 16'hFFFF : 16'(16'h1234 ^ seed);
    bclk = ones ? 16'hFFFF : 16'(16'hC300 + seed * 3);
    amu  = ones ? 16'hFFFF : 16'(16'h2A15 + seed);
    for (int i = 0; i < NCH; i++)
      chan[i*SW +: SW] = ones ? '1 : SW'(seed * 37 + i * 13);
    for (int u = 0; u < NUSER; u++)
      user[u*16 +: 16] = ones ? 16'hFFFF : 16'(seed * 1000 + u * 257 + 16'h4400);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    set_inputs(1, 1'b0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy_o && !cav_o && !dav_o && word_o == 16'h0, "R1",
          {13'b0, busy_o, cav_o, dav_o, word_o}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    phase = "R2 R3 plain";
    pulse_start();
    wait_idle();
    repeat (3) @(negedge clk);

    // R9 inputs rewritten mid-packet and R8 starts ignored while busy
    phase = "R9 R8 restart ignored";
    set_inputs(2, 1'b0);
    pulse_start();
    repeat (20) @(negedge clk);
    set_inputs(3, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    pulse_start();
    wait_idle();

    // R10 start in the first idle cycle
    phase = "R10 back-to-back";
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);

    // R4 R5 upper bits masked with all-ones inputs
    phase = "R4 R5 masking";
    set_inputs(0, 1'b1);
    pulse_start();
    wait_idle();
    repeat (2) @(negedge clk);

    // R10 start held high across packets
    phase = "R10 held start";
    set_inputs(4, 1'b0);
    start = 1'b1;
    repeat (600) @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    finish_sim();
  end

endmodule